// File: doc/BRIEF.md
# PCM Serial Port with Frame-Type Auto-Detect

This block is the serial PCM port of an 8 kHz voice codec. It works beside a fast system clock and oversamples the bit clock, the frame sync, the serial input and the active-low mute input. In each frame it sends one 14-bit transmit sample and receives one 14-bit receive sample. Both samples travel as 16-bit two's-complement words, most significant bit first, in the first time slot of the frame. The frame holds 32 or 64 bit clocks. The two bits below the sample are sent as zero and are dropped on receive.

No mode pin is needed. The port measures how long frame sync stays high, counted in bit-clock falling edges, and from that decides whether the frame uses long or short timing. The serial output comes with its own output-enable so that an outside pad can tri-state the line. The enable is high only during the port's own slot. Mute takes effect at the next slot boundary, never inside a word. While mute is active the receive side hands up the zero code.

Top module: `pcm_port`

## Requirements
- R1: Frame sync is sampled on bit-clock falling edges. If a pulse is seen high at exactly one falling edge, the frame is short. If it is seen high at two or more, the frame is long. The receive path aligns to the type of the current pulse.
- R2: The transmit path aligns to the type measured from the previous frame-sync pulse. In long mode the first bit is driven once frame sync and the bit clock are both high, so it follows whichever of the two rose later. In short mode the first bit is driven at the bit-clock rising edge that follows the falling edge at which the pulse was seen.
- R3: The transmitted word is {tx_sample_i, 2'b00}, 16 bits, sent MSB first. Each bit changes only on a bit-clock rising edge. tx_sample_i is taken when the slot starts.
- R4: sdo_oe_o is high for exactly the 16 bit periods of the slot and low for the rest of the frame. This holds at 32 and at 64 bit clocks per frame. sdo_o is 0 whenever sdo_oe_o is low.
- R5: sdi_i is sampled on bit-clock falling edges. In a long frame the 16 samples start at the falling edge where frame sync is first seen high. In a short frame they start one falling edge later. rx_sample_o receives word bits 15:2, and bits 1:0 have no effect.
- R6: rx_valid_o pulses high for one system-clock cycle once per frame, after the 16th bit is captured. rx_sample_o is updated with that pulse and then held.
- R7: If mute_ni is low when a slot starts, sdo_oe_o stays low for that whole frame. If mute_ni falls during a slot, the word still completes, and silence begins with the next frame.
- R8: If mute_ni is low when the 16th receive bit is captured, rx_sample_o is loaded with 14'h0000. rx_valid_o still pulses.
- R9: While rst_ni is low, sdo_oe_o, rx_valid_o and rx_sample_o are all zero. After reset the transmit type is long.
- R10: The full-scale codes 14'h1FFF and 14'h2000, the zero code 14'h0000 and the code 14'h3FFF pass through both directions unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | PCM bit clock |
| fs_i | input | 1 | 8 kHz frame sync |
| sdi_i | input | 1 | Serial receive data |
| mute_ni | input | 1 | Mute request, active low |
| tx_sample_i | input | SAMPLE_W | Sample to transmit in the next slot |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| rx_sample_o | output | SAMPLE_W | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe when rx_sample_o updates |

## Verification
The bench drives frame syncs one bit clock wide and several bit clocks wide, and changes the type between consecutive frames. A port that used the current pulse for transmit, or the previous pulse for receive, would shift the word by one bit and corrupt every bit of the check. The bench also places junk in the two pad bits, in the bits outside the slot, and in the extra bit captured at the start of a short frame. A port that kept any of these would show wrong sample bits. Mute is dropped in the middle of a slot: a port that cut the word short, or that kept driving the next frame, would give the wrong enable window. A reset taken after short frames must put the transmit side back to long alignment.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {FRAME_SHORT = 1'b0, FRAME_LONG = 1'b1} frame_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_frame_det.sv
module pcm_frame_det
  import pcm_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_s_i,
  input  logic fs_s_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,   // falling edge that first sees frame sync high
  output logic launch_o   // transmit slot begins this cycle
);
  logic   bclk_d_q, fs_fall_q, second_q, pend_q, armed_q;
  frame_e mode_q;
  logic   long_go;

  assign rise_o  = bclk_s_i & ~bclk_d_q;
  assign fall_o  = ~bclk_s_i & bclk_d_q;
  assign start_o = fall_o & fs_s_i & ~fs_fall_q;
  // long timing: first bit once both frame sync and bit clock are high
  assign long_go = fs_s_i & bclk_s_i & ~armed_q;
  assign launch_o = (mode_q == FRAME_LONG) ? long_go : (rise_o & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d_q  <= 1'b0;
      fs_fall_q <= 1'b0;
      second_q  <= 1'b0;
      pend_q    <= 1'b0;
      armed_q   <= 1'b0;
      mode_q    <= FRAME_LONG;
    end else begin
      bclk_d_q <= bclk_s_i;
      if (!fs_s_i)       armed_q <= 1'b0;
      else if (bclk_s_i) armed_q <= 1'b1;
      if (fall_o) begin
        fs_fall_q <= fs_s_i;
        second_q  <= start_o;
        pend_q    <= start_o;
        // second falling edge of the pulse decides the type
        if (second_q) mode_q <= fs_s_i ? FRAME_LONG : FRAME_SHORT;
      end else if (rise_o) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                rise_i,
  input  logic                mute_n_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sdo_o,
  output logic                oe_o
);
  localparam int PAD_W = WORD_W - SAMPLE_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (launch_i) begin
      sh_q  <= {sample_i, {PAD_W{1'b0}}};
      cnt_q <= CNT_W'(1);
      oe_q  <= mute_n_i;  // mute only acts at a slot boundary
    end else if (rise_i && oe_q) begin
      if (cnt_q == CNT_W'(WORD_W)) begin
        oe_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sdo_o = oe_q & sh_q[WORD_W-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                start_i,
  input  logic                fs_s_i,
  input  logic                sdi_s_i,
  input  logic                mute_n_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [WORD_W-1:0]   sh_q, sh_nx;
  logic [CNT_W-1:0]    cnt_q;
  logic                act_q, long_q, long_now, done;
  logic [SAMPLE_W-1:0] sample_q;
  logic                valid_q;

  assign sh_nx    = {sh_q[WORD_W-2:0], sdi_s_i};
  assign long_now = (cnt_q == CNT_W'(1)) ? fs_s_i : long_q;
  // short frames capture one leading extra bit, so they end one edge later
  assign done = long_now ? (cnt_q == CNT_W'(WORD_W - 1)) : (cnt_q == CNT_W'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      act_q    <= 1'b0;
      long_q   <= 1'b1;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (fall_i) begin
        if (start_i) begin
          sh_q  <= sh_nx;
          cnt_q <= CNT_W'(1);
          act_q <= 1'b1;
        end else if (act_q) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(1)) long_q <= fs_s_i;
          if (done) begin
            act_q    <= 1'b0;
            valid_q  <= 1'b1;
            sample_q <= mute_n_i ? sh_nx[WORD_W-1 -: SAMPLE_W] : '0;
          end
        end
      end
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
  parameter int SAMPLE_W    = 14,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                fs_i,
  input  logic                sdi_i,
  input  logic                mute_ni,
  input  logic [SAMPLE_W-1:0] tx_sample_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic [SAMPLE_W-1:0] rx_sample_o,
  output logic                rx_valid_o
);
  logic [3:0] pins_s;
  logic       bclk_s, fs_s, sdi_s, mute_n_s;
  logic       rise_w, fall_w, start_w, launch_w;

  pcm_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mute_ni, sdi_i, fs_i, bclk_i}),
    .q_o    (pins_s)
  );
  assign {mute_n_s, sdi_s, fs_s, bclk_s} = pins_s;

  pcm_frame_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_s_i (bclk_s),
    .fs_s_i   (fs_s),
    .rise_o   (rise_w),
    .fall_o   (fall_w),
    .start_o  (start_w),
    .launch_o (launch_w)
  );

  pcm_tx #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch_w),
    .rise_i   (rise_w),
    .mute_n_i (mute_n_s),
    .sample_i (tx_sample_i),
    .sdo_o    (sdo_o),
    .oe_o     (sdo_oe_o)
  );

  pcm_rx #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall_w),
    .start_i  (start_w),
    .fs_s_i   (fs_s),
    .sdi_s_i  (sdi_s),
    .mute_n_i (mute_n_s),
    .sample_o (rx_sample_o),
    .valid_o  (rx_valid_o)
  );
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
  parameter int SAMPLE_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bclk_s_i,
  input logic                rise_i,
  input logic                fall_i,
  input logic                mute_n_i,
  input logic                sdo_o,
  input logic                sdo_oe_o,
  input logic [SAMPLE_W-1:0] rx_sample_o,
  input logic                rx_valid_o
);
  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_valid_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(fall_i));

  assert_slot_start_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(bclk_s_i));

  assert_bit_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $past(rise_i));

  assert_slot_end_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> $past(rise_i));

  assert_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  assert_mute_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !$past(mute_n_i)) |-> (rx_sample_o == '0));
endmodule

bind pcm_port pcm_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bclk_s_i    (bclk_s),
  .rise_i      (rise_w),
  .fall_i      (fall_w),
  .mute_n_i    (mute_n_s),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .rx_sample_o (rx_sample_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/test_pcm_port.sv
module test_pcm_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_i = 1'b0, fs_i = 1'b0, sdi_i = 1'b0, mute_ni = 1'b1;
  logic [13:0] tx_sample_i = '0;
  logic        sdo_o, sdo_oe_o, rx_valid_o;
  logic [13:0] rx_sample_o;

  int checks = 0, errors = 0, vcnt = 0;
  logic [13:0] last_rx = '0;
  logic        prev_long = 1'b1;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pcm_port i_pcm_port (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk_i), .fs_i(fs_i), .sdi_i(sdi_i),
    .mute_ni(mute_ni), .tx_sample_i(tx_sample_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .rx_sample_o(rx_sample_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) if (rst_ni && rx_valid_o) begin
    vcnt++;
    last_rx = rx_sample_o;
  end

  // {frame-sync width in bits, tx sample, 16-bit rx word}
  localparam logic [33:0] VEC [8] = '{
    {4'd2, 14'h1FFF, 16'h8003},
    {4'd3, 14'h2000, 16'h7FFE},
    {4'd1, 14'h0000, 16'hFFFF},
    {4'd1, 14'h1555, 16'h5A5A},
    {4'd1, 14'h2AAA, 16'h0001},
    {4'd8, 14'h0ABC, 16'hC3C3},
    {4'd2, 14'h1234, 16'h1235},
    {4'd1, 14'h3FFF, 16'h0002}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int nb, input int fslen, input logic [13:0] tx,
                           input logic [15:0] rxw, input int mute_bit, input logic mute_val,
                           input string txtag, input string rxtag);
    logic [63:0] obs_oe = '0, obs_sdo = '0, exp_oe = '0, exp_sdo = '0;
    logic [15:0] word = {tx, 2'b00};
    int s  = prev_long ? 0 : 1;
    int rs = (fslen >= 2) ? 0 : 1;
    logic en = mute_ni;
    int v0 = vcnt;
    tx_sample_i = tx;
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      if (b == mute_bit) mute_ni = mute_val;
      bclk_i = 1'b1;
      fs_i   = (b < fslen);
      sdi_i  = (b >= rs && b < rs + 16) ? rxw[15 - (b - rs)] : 1'b1;
      repeat (6) @(negedge clk);
      obs_oe[b]  = sdo_oe_o;
      obs_sdo[b] = sdo_o;
      exp_oe[b]  = en && (b >= s) && (b < s + 16);
      exp_sdo[b] = exp_oe[b] ? word[15 - (b - s)] : 1'b0;
      repeat (2) @(negedge clk);
      bclk_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk({"R4 enable window ", txtag}, obs_oe, exp_oe);
    chk({"R3 transmit bits ", txtag}, obs_sdo & exp_oe, exp_sdo);
    chk({"R6 one strobe per frame ", rxtag}, 64'(vcnt - v0), 64'd1);
    chk({"R5 receive sample ", rxtag}, 64'(last_rx), mute_ni ? 64'(rxw[15:2]) : 64'd0);
    prev_long = (fslen >= 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual 200000 cycles expected fewer");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 oe in reset", 64'(sdo_oe_o), 64'd0);
    chk("R9 rx sample in reset", 64'(rx_sample_o), 64'd0);
    chk("R9 valid in reset", 64'(rx_valid_o), 64'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // vector walk: type changes, pad bits, full-scale codes (R1 R2 R10)
    foreach (VEC[i]) begin
      run_frame(32, int'(VEC[i][33:30]), VEC[i][29:16], VEC[i][15:0], -1, 1'b1,
                "R1 R2 R10", "R1 R10");
    end

    // 64 bit clocks per frame: slot only in the first 16 bits
    run_frame(64, 2, 14'h0F0F, 16'hA5A4, -1, 1'b1, "R4 64-bit frame", "R5 64-bit frame");
    run_frame(64, 1, 14'h3001, 16'h1003, -1, 1'b1, "R4 64-bit short", "R5 64-bit short");

    // mute falls mid-slot: word completes, rx zero
    run_frame(32, 2, 14'h1ABC, 16'h6789, 5, 1'b0, "R7 word completes", "R8 muted capture");
    // muted at slot start: no enable
    run_frame(32, 2, 14'h0777, 16'h4444, -1, 1'b0, "R7 muted frame", "R8 muted frame");
    mute_ni = 1'b1;
    run_frame(32, 1, 14'h1001, 16'h2222, -1, 1'b1, "R7 unmuted", "R5 unmuted");
    run_frame(32, 1, 14'h0002, 16'h3334, -1, 1'b1, "R2 short", "R5 short");

    // reset after short frames: transmit type back to long
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 oe in reset", 64'(sdo_oe_o), 64'd0);
    chk("R9 rx sample cleared", 64'(rx_sample_o), 64'd0);
    chk("R9 valid in reset", 64'(rx_valid_o), 64'd0);
    rst_ni = 1'b1;
    prev_long = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(32, 1, 14'h2468, 16'h1359, -1, 1'b1, "R9 long after reset", "R1 short rx");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule